// File: doc/BRIEF.md
# Instruction Prefetch Sequencer with Branch Stall

The sequencer reads a stream of variable-length instructions from a word-addressed instruction bus. It assembles each instruction, which is an opcode word plus zero, one or two 32-bit extension words, and places it in a small queue that runs ahead of the execute stage. The sequencer reads only the unit-select fields of the opcode. From those it learns how many extension words follow and whether the instruction redirects control flow.

Every queued entry carries the address just past its own last word. This means a program-counter read made by execute is correct however far fetch has run ahead. When an instruction that writes a control-flow unit enters the queue, fetch issues no further requests. Fetch stays stopped until execute has taken that instruction and reported the outcome on the resolve pins. On a taken outcome the queue is flushed and fetch restarts at the reported target. On a not-taken outcome fetch carries on from where it stopped. The queue therefore never holds an instruction from the wrong path.

The instruction bus request side is valid/ready. While `ib_req_valid` is high and `ib_req_ready` is low, the request and its address must stay unchanged. At most one read is outstanding. Its data returns on a later cycle with `ib_rsp_valid`, and the sequencer always accepts it. Toward execute, `instr_valid` is level-based. `instr_accept` is a single-cycle take of the head entry and has no effect while `instr_valid` is low.

Top module: `prefetch_seq`

## Requirements
- R1: During and after reset, `instr_valid` is low, all `dec_*` outputs are zero, and the first instruction-bus request goes to address 0.
- R2: The opcode source-unit field is bits [4:0] and the destination-unit field is bits [9:5]. Source codes 12, 14 and 19 each add one extension word, and destination codes 12 and 19 each add one. An instruction is therefore 1 to 3 words long. The pred, immediate and reserved bits do not affect length.
- R3: When both extension words are present, the source extension word comes first. It is presented on `dec_src_word` and the destination extension word on `dec_dst_word`. A word the instruction does not have reads as zero.
- R4: `dec_next_pc` equals the instruction's address plus its word count.
- R5: The queue holds 2 complete instructions. If execute accepts nothing, fetch stops after the words of the first two instructions have been requested.
- R6: An `instr_accept` while `instr_valid` is high loads the head entry into the `dec_*` outputs on the next clock edge, in program order. An `instr_accept` while `instr_valid` is low is ignored, and the `dec_*` outputs keep their values.
- R7: After an instruction whose destination code is 15, 16 or 27 enters the queue, no instruction-bus request is made until a resolve strobe arrives.
- R8: A resolve with `rslv_taken` high flushes the queue, and fetch restarts at `rslv_target`. The next instruction accepted is the one at the target.
- R9: A resolve with `rslv_taken` low resumes fetch at the address that follows the control-flow instruction.
- R10: A request held off by `ib_req_ready` keeps `ib_req_valid` high and `ib_req_addr` unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ib_req_valid | output | 1 | Instruction-bus read request |
| ib_req_ready | input | 1 | Bus accepts the request this cycle |
| ib_req_addr | output | AW | Word address of the read |
| ib_rsp_valid | input | 1 | Read data is present |
| ib_rsp_data | input | 32 | Read data word |
| instr_valid | output | 1 | A complete instruction waits at the queue head |
| instr_accept | input | 1 | Execute takes the head entry |
| dec_opcode | output | 32 | Opcode of the last accepted instruction |
| dec_src_word | output | 32 | Source extension word, or zero |
| dec_dst_word | output | 32 | Destination extension word, or zero |
| dec_next_pc | output | AW | Address following the accepted instruction |
| rslv_valid | input | 1 | Execute reports the control-flow outcome |
| rslv_taken | input | 1 | The control-flow instruction redirects |
| rslv_target | input | AW | Redirect address |

## Verification
The bench builds the block with its default 32-bit address and 2-entry queue. It uses a bus model with two cycles of read latency and a ready signal that is low one cycle in three. The 2-entry depth makes queue-full back-pressure reachable within a few instructions, and the stalled ready signal exercises request holding. The program contains instructions of every length, a not-taken conditional branch, a taken jump and a taken call. Decoy instructions are placed directly after each taken branch, so any wrong-path fetch shows up as a request to an address that must never be read.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPW = 32;

  typedef struct packed {
    logic [3:0] rsvd;
    logic [1:0] pred;
    logic [7:0] dimm;
    logic [7:0] simm;
    logic [4:0] dst;
    logic [4:0] src;
  } opword_t;

  // unit codes that matter for length and control flow
  localparam logic [4:0] U_MEM_WIDE = 5'd12;
  localparam logic [4:0] U_LIT_WIDE = 5'd14;
  localparam logic [4:0] U_PC       = 5'd15;
  localparam logic [4:0] U_PC_IF    = 5'd16;
  localparam logic [4:0] U_BYTE     = 5'd19;
  localparam logic [4:0] U_CALL     = 5'd27;
endpackage

// File: rtl/seq_len_decode.sv
module seq_len_decode
  import seq_pkg::*;
(
  input  logic [OPW-1:0] word,
  output logic           src_ext,
  output logic           dst_ext,
  output logic           ctrl
);
  opword_t ow;
  assign ow = opword_t'(word);

  always_comb begin
    src_ext = (ow.src == U_MEM_WIDE) || (ow.src == U_LIT_WIDE) || (ow.src == U_BYTE);
    dst_ext = (ow.dst == U_MEM_WIDE) || (ow.dst == U_BYTE);
    ctrl    = (ow.dst == U_PC) || (ow.dst == U_PC_IF) || (ow.dst == U_CALL);
  end
endmodule

// File: rtl/seq_queue.sv
module seq_queue #(
  parameter int W     = 128,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  input  logic                         flush,
  output logic [W-1:0]                 head,
  output logic                         valid,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic          pop_e;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign pop_e = pop && (count != '0);
  assign valid = (count != '0);
  assign head  = slot[rd_p];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_p  <= '0;
      wr_p  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        slot[wr_p] <= push_data;
        wr_p       <= step(wr_p);
      end
      if (pop_e) rd_p <= step(rd_p);
      count <= count + CW'(push) - CW'(pop_e);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_e) |-> (count < CW'(DEPTH)));
endmodule

// File: rtl/prefetch_seq.sv
module prefetch_seq
  import seq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QDEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           ib_req_valid,
  input  logic           ib_req_ready,
  output logic [AW-1:0]  ib_req_addr,
  input  logic           ib_rsp_valid,
  input  logic [31:0]    ib_rsp_data,
  output logic           instr_valid,
  input  logic           instr_accept,
  output logic [31:0]    dec_opcode,
  output logic [31:0]    dec_src_word,
  output logic [31:0]    dec_dst_word,
  output logic [AW-1:0]  dec_next_pc,
  input  logic           rslv_valid,
  input  logic           rslv_taken,
  input  logic [AW-1:0]  rslv_target
);
  localparam int EW = 3*OPW + AW;
  localparam int CW = $clog2(QDEPTH+1);

  // fetch and assembly state
  logic [AW-1:0]  fpc;
  logic           outst, hold, in_body;
  logic [OPW-1:0] a_op, a_sw;
  logic           a_sx, a_dx, a_cf, a_idx;

  logic           d_sx, d_dx, d_cf;
  logic           take, last, q_push, q_flush, q_valid, push_cf, rslv_ok;
  logic [OPW-1:0] p_op, p_sw, p_dw;
  logic [EW-1:0]  q_head;
  logic [CW-1:0]  q_count;

  seq_len_decode u_dec (
    .word    (ib_rsp_data),
    .src_ext (d_sx),
    .dst_ext (d_dx),
    .ctrl    (d_cf)
  );

  assign take    = ib_rsp_valid && outst;
  assign rslv_ok = rslv_valid && hold;
  assign q_flush = rslv_ok && rslv_taken;

  assign ib_req_valid = !outst && !hold && (q_count < CW'(QDEPTH));
  assign ib_req_addr  = fpc;

  always_comb begin
    last = (a_sx && a_dx) ? a_idx : !a_idx;
    if (!in_body) begin
      q_push  = take && !d_sx && !d_dx;
      p_op    = ib_rsp_data;
      p_sw    = '0;
      p_dw    = '0;
      push_cf = d_cf;
    end else begin
      q_push  = take && last;
      p_op    = a_op;
      p_sw    = (a_sx && !a_idx) ? ib_rsp_data : a_sw;
      p_dw    = a_dx ? ib_rsp_data : '0;
      push_cf = a_cf;
    end
  end

  seq_queue #(.W(EW), .DEPTH(QDEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data ({p_op, p_sw, p_dw, fpc}),
    .pop       (instr_accept),
    .flush     (q_flush),
    .head      (q_head),
    .valid     (q_valid),
    .count     (q_count)
  );

  assign instr_valid = q_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpc     <= '0;
      outst   <= 1'b0;
      hold    <= 1'b0;
      in_body <= 1'b0;
      a_op    <= '0;
      a_sw    <= '0;
      a_sx    <= 1'b0;
      a_dx    <= 1'b0;
      a_cf    <= 1'b0;
      a_idx   <= 1'b0;
    end else begin
      if (ib_req_valid && ib_req_ready) begin
        fpc   <= fpc + AW'(1);
        outst <= 1'b1;
      end
      if (take) begin
        outst <= 1'b0;
        if (!in_body) begin
          a_op    <= ib_rsp_data;
          a_sw    <= '0;
          a_sx    <= d_sx;
          a_dx    <= d_dx;
          a_cf    <= d_cf;
          a_idx   <= 1'b0;
          in_body <= d_sx || d_dx;
        end else if (last) begin
          in_body <= 1'b0;
        end else begin
          a_idx <= 1'b1;
          a_sw  <= ib_rsp_data;
        end
      end
      if (q_push && push_cf) hold <= 1'b1;
      if (rslv_ok) begin
        hold <= 1'b0;
        if (rslv_taken) fpc <= rslv_target;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_opcode   <= '0;
      dec_src_word <= '0;
      dec_dst_word <= '0;
      dec_next_pc  <= '0;
    end else if (instr_accept && q_valid) begin
      {dec_opcode, dec_src_word, dec_dst_word, dec_next_pc} <= q_head;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req_valid && !ib_req_ready) |=> (ib_req_valid && $stable(ib_req_addr)));

  // R7
  no_wrong_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !q_push);

  // R6
  dec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_accept && instr_valid) |=> ($stable(dec_opcode) && $stable(dec_next_pc)));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |=> !instr_valid);
endmodule

// File: tb/tb_prefetch_seq.sv
module tb_prefetch_seq;
  localparam int CLK_NS = 10;
  localparam int LAT    = 2;
  localparam int NV     = 10;

  // per row: [4]=address [3]=opcode [2]=src word [1]=dst word [0]=taken target (0 = not taken)
  localparam logic [4:0][31:0] VEC [NV] = '{
    '{32'd0,  32'h0000146D, 32'h0,        32'h0,        32'h0},
    '{32'd1,  32'h0000006E, 32'h11111111, 32'h0,        32'h0},
    '{32'd3,  32'h0000018C, 32'hAAAA0003, 32'hBBBB0003, 32'h0},
    '{32'd6,  32'h00080263, 32'h0,        32'hCCCC0006, 32'h0},
    '{32'd8,  32'h00000213, 32'hDDDD0008, 32'h0,        32'h0},
    '{32'd10, 32'h040001ED, 32'h0,        32'h0,        32'd20},
    '{32'd20, 32'h0000036E, 32'h0000001E, 32'h0,        32'd30},
    '{32'd30, 32'hF003FC00, 32'h0,        32'h0,        32'h0},
    '{32'd31, 32'h000000AE, 32'h12345678, 32'h0,        32'h0},
    '{32'd33, 32'h0000006C, 32'h55550034, 32'h0,        32'h0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ib_req_valid, ib_req_ready = 1'b0, ib_rsp_valid = 1'b0;
  logic [31:0] ib_req_addr, ib_rsp_data = '0;
  logic        instr_valid, instr_accept = 1'b0;
  logic [31:0] dec_opcode, dec_src_word, dec_dst_word, dec_next_pc;
  logic        rslv_valid = 1'b0, rslv_taken = 1'b0;
  logic [31:0] rslv_target = '0;

  prefetch_seq dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0, nfail = 0, hs_count = 0, wrong_path = 0, bad_hold = 0, cyc = 0, cnt = 0;
  logic [31:0] first_addr = 32'hFFFFFFFF, paddr = '0, prev_addr = '0;
  logic pend = 1'b0, prev_stall = 1'b0, done = 1'b0;
  logic [31:0] mem [64];

  function automatic bit sx(input logic [31:0] op);
    return op[4:0] == 5'd12 || op[4:0] == 5'd14 || op[4:0] == 5'd19;
  endfunction
  function automatic bit dx(input logic [31:0] op);
    return op[9:5] == 5'd12 || op[9:5] == 5'd19;
  endfunction
  function automatic bit cf(input logic [31:0] op);
    return op[9:5] == 5'd15 || op[9:5] == 5'd16 || op[9:5] == 5'd27;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // memory image built from the table, decoys after taken branches
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < NV; i++) begin
      int k;
      k = int'(VEC[i][4]);
      mem[k] = VEC[i][3];
      k++;
      if (sx(VEC[i][3])) begin mem[k] = VEC[i][2]; k++; end
      if (dx(VEC[i][3])) mem[k] = VEC[i][1];
    end
    mem[11] = 32'h0000008D;
    mem[22] = 32'h0000008D;
  end

  // instruction bus model, updated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      ib_req_ready = 1'b0;
      ib_rsp_valid = 1'b0;
      pend = 1'b0;
      prev_stall = 1'b0;
    end else begin
      cyc++;
      ib_rsp_valid = 1'b0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin
          ib_rsp_valid = 1'b1;
          ib_rsp_data  = mem[paddr[5:0]];
          pend = 1'b0;
        end
      end
      ib_req_ready = (cyc % 3) != 1;
      if (prev_stall && !(ib_req_valid && ib_req_addr == prev_addr)) bad_hold++;
      prev_stall = ib_req_valid && !ib_req_ready;
      prev_addr  = ib_req_addr;
      if (ib_req_valid && ib_req_ready) begin
        hs_count++;
        if (first_addr == 32'hFFFFFFFF) first_addr = ib_req_addr;
        if ((ib_req_addr >= 11 && ib_req_addr <= 19) || (ib_req_addr >= 22 && ib_req_addr <= 29))
          wrong_path++;
        pend = 1'b1;
        paddr = ib_req_addr;
        cnt = LAT;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    string lbl;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(instr_valid == 1'b0, "R1 instr_valid", {31'd0, instr_valid}, 32'd0);
    chk(dec_opcode == 32'd0, "R1 dec_opcode", dec_opcode, 32'd0);
    chk(dec_next_pc == 32'd0, "R1 dec_next_pc", dec_next_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 accept without valid is ignored
    chk(instr_valid == 1'b0, "R6 empty queue", {31'd0, instr_valid}, 32'd0);
    instr_accept = 1'b1;
    @(negedge clk);
    instr_accept = 1'b0;
    repeat (40) @(negedge clk);
    chk(dec_opcode == 32'd0, "R6 ignored accept", dec_opcode, 32'd0);
    // R5 two entries then fetch stops: 1 + 2 words
    chk(hs_count == 3, "R5 words fetched while full", hs_count, 32'd3);
    chk(instr_valid == 1'b1, "R5 head valid", {31'd0, instr_valid}, 32'd1);
    chk(first_addr == 32'd0, "R1 first fetch address", first_addr, 32'd0);

    lbl = "R6";
    for (int i = 0; i < NV; i++) begin
      logic [31:0] op, exp_npc;
      op = VEC[i][3];
      exp_npc = VEC[i][4] + 32'd1 + 32'(sx(op)) + 32'(dx(op));
      while (!instr_valid) @(negedge clk);
      instr_accept = 1'b1;
      @(negedge clk);
      instr_accept = 1'b0;
      chk(dec_opcode == op, {lbl, " opcode order"}, dec_opcode, op);
      chk(dec_src_word == VEC[i][2], "R3 source word", dec_src_word, VEC[i][2]);
      chk(dec_dst_word == VEC[i][1], "R3 destination word", dec_dst_word, VEC[i][1]);
      chk(dec_next_pc == exp_npc, "R2 R4 next pc", dec_next_pc, exp_npc);
      lbl = "R6";
      if (cf(op)) begin
        // R7 nothing further arrives before the outcome
        repeat (6) @(negedge clk);
        chk(instr_valid == 1'b0, "R7 stalled behind branch", {31'd0, instr_valid}, 32'd0);
        rslv_valid  = 1'b1;
        rslv_taken  = VEC[i][0] != 32'd0;
        rslv_target = VEC[i][0];
        lbl = rslv_taken ? "R8" : "R9";
        @(negedge clk);
        rslv_valid = 1'b0;
        rslv_taken = 1'b0;
      end
    end
    repeat (10) @(negedge clk);
    chk(wrong_path == 0, "R7 R8 wrong-path requests", wrong_path, 32'd0);
    chk(bad_hold == 0, "R10 request held stable", bad_hold, 32'd0);
    finish_run();
  end
endmodule